// File: doc/BRIEF.md
# Byte SPI Master with Register Access

This block is a serial peripheral interface master that moves one byte at a time. Software reaches it through a 32-bit register port with separate write and read strobes. It sets clock polarity, clock phase and bit rate in a configuration register, then writes a byte to the transmit register. The block shifts that byte out most significant bit first and captures the byte the device returns on the same edges. It then holds the received byte and raises a receive-full flag.

The serial clock comes from a bus-clock prescaler with two stages. The first stage is a coarse divider of 16 or 128. The second is a fine divider that spends N+1 coarse ticks on each half of the serial clock. The chip-select line is not tied to transfers. It follows one register bit, so software decides how many bytes share one select window.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, registers read zero except the system register, which reads 0x40. The chip select is high and the serial clock is low.
- R2: Bit 6 of the system register (offset 0x08) drives the chip-select output directly: 0 drives it low and 1 drives it high. The written value reads back in full, so 0x21 reads back as 0x21 and selects the device.
- R3: While no transfer runs, the serial clock rests at the polarity bit (bit 6 of the configuration register at offset 0x00).
- R4: Each half period of the serial clock lasts P*(N+1) bus clocks. P is 128 when configuration bit 5 is 1 and 16 when it is 0. N is configuration bits 4:0.
- R5: Status bit 0 (offset 0x04) reads 1 from the cycle after a transmit write until the received byte has been stored. It then returns to 0.
- R6: A transfer makes exactly 16 serial clock transitions and ends at the rest level. Data goes out on the data output most significant bit first. With phase bit 7 at 0, data is valid at the first edge of each bit; with phase bit 7 at 1, it is valid at the second edge.
- R7: At the end of a transfer, the byte sampled from the data input, most significant bit first, appears in bits 7:0 of the receive register (offset 0x10). Status bit 2 becomes 1.
- R8: A read of the receive register clears status bit 2.
- R9: A write to the status register with bit 2 at 0 clears status bit 2.
- R10: A write to the transmit register (offset 0x0C) while status bit 0 is 1 is ignored. The running byte completes unchanged and no second transfer follows.
- R11: The second configuration register (offset 0x14) stores and returns its low 8 bits. The transmit register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (for clear-on-read side effects) |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| csN | output | 1 | Chip select, active low |

## Verification
A wrong prescaler count changes the gap between serial clock transitions from the first half period. It is measured against P*(N+1) on every transition. A wrong edge index or wrong shift/sample choice shows up before the end of the first byte. The device model then captures a different byte, the returned byte is wrong, or the count of 16 transitions or the final rest level is off. A stuck busy or receive-full state shows on the next status read, and an accepted mid-transfer write changes the captured byte.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W  = 8;
  localparam int FINE_W  = 5;
  localparam int ADDR_W  = 5;
  localparam int BUS_W   = 32;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SYS  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TX   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RX   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG2 = 5'h14;

  typedef struct packed {
    logic              start;
    logic [BYTE_W-1:0] txByte;
    logic              cpol;
    logic              cpha;
    logic              coarseHi;
    logic [FINE_W-1:0] fineN;
  } spimCmd_t;
endpackage

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimCmd_t          cmd,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int PRE_CW  = $clog2(PRE_HI);
  localparam int EDGES   = 2 * BYTE_W;
  localparam int EDGE_CW = $clog2(EDGES);
  localparam logic [PRE_CW-1:0]  LIM_LO   = PRE_CW'(PRE_LO - 1);
  localparam logic [PRE_CW-1:0]  LIM_HI   = PRE_CW'(PRE_HI - 1);
  localparam logic [EDGE_CW-1:0] LAST_IDX = EDGE_CW'(EDGES - 1);

  logic               active, doneQ, sckQ;
  logic               cphaQ, hiQ;
  logic [FINE_W-1:0]  nQ, fineCnt;
  logic [PRE_CW-1:0]  preCnt;
  logic [EDGE_CW-1:0] edgeIdx;
  logic [BYTE_W-1:0]  txSh, rxSh;
  logic               preTick, edgeEv, shiftEv, sampleEv;

  assign preTick  = active && (preCnt == (hiQ ? LIM_HI : LIM_LO));
  assign edgeEv   = preTick && (fineCnt == nQ);
  // phase 0: shift on trailing edges; phase 1: shift on leading edges after the first
  assign shiftEv  = cphaQ ? (!edgeIdx[0] && (edgeIdx != '0)) : edgeIdx[0];
  assign sampleEv = cphaQ ? edgeIdx[0] : !edgeIdx[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      doneQ   <= 1'b0;
      sckQ    <= 1'b0;
      cphaQ   <= 1'b0;
      hiQ     <= 1'b0;
      nQ      <= '0;
      fineCnt <= '0;
      preCnt  <= '0;
      edgeIdx <= '0;
      txSh    <= '0;
      rxSh    <= '0;
    end else begin
      doneQ <= 1'b0;
      if (cmd.start && !active) begin
        active  <= 1'b1;
        preCnt  <= '0;
        fineCnt <= '0;
        edgeIdx <= '0;
        txSh    <= cmd.txByte;
        cphaQ   <= cmd.cpha;
        hiQ     <= cmd.coarseHi;
        nQ      <= cmd.fineN;
        sckQ    <= cmd.cpol;
      end else if (active) begin
        preCnt <= preTick ? '0 : preCnt + 1'b1;
        if (preTick) fineCnt <= (fineCnt == nQ) ? '0 : fineCnt + 1'b1;
        if (edgeEv) begin
          sckQ    <= ~sckQ;
          edgeIdx <= edgeIdx + 1'b1;
          if (shiftEv)  txSh <= {txSh[BYTE_W-2:0], 1'b0};
          if (sampleEv) rxSh <= {rxSh[BYTE_W-2:0], miso};
          if (edgeIdx == LAST_IDX) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end
        end
      end else begin
        sckQ <= cmd.cpol;
      end
    end
  end

  assign sck    = sckQ;
  assign mosi   = txSh[BYTE_W-1];
  assign busy   = active | doneQ;
  assign done   = doneQ;
  assign rxByte = rxSh;

  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!active && $past(!active) && $stable(cmd.cpol)) |-> (sckQ == cmd.cpol));
  a_r5_start_begins: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(cmd.start));
  a_r6_end_marks_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> doneQ);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rxByte,
  output spimCmd_t          cmd,
  output logic              csN
);
  localparam logic [BYTE_W-1:0] SYS_RST = 8'h40;
  localparam int PAD = BUS_W - BYTE_W;

  logic [BYTE_W-1:0] cfgQ, sysQ, cfg2Q, rxBufQ;
  logic              rxFullQ;
  logic              wrCfg, wrStat, wrSys, wrTx, wrCfg2, rdRx;

  assign wrCfg  = wrEn && (addr == OFS_CFG);
  assign wrStat = wrEn && (addr == OFS_STAT);
  assign wrSys  = wrEn && (addr == OFS_SYS);
  assign wrTx   = wrEn && (addr == OFS_TX);
  assign wrCfg2 = wrEn && (addr == OFS_CFG2);
  assign rdRx   = rdEn && (addr == OFS_RX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      sysQ    <= SYS_RST;
      cfg2Q   <= '0;
      rxBufQ  <= '0;
      rxFullQ <= 1'b0;
    end else begin
      if (wrCfg)  cfgQ  <= wdata[BYTE_W-1:0];
      if (wrSys)  sysQ  <= wdata[BYTE_W-1:0];
      if (wrCfg2) cfg2Q <= wdata[BYTE_W-1:0];
      if (done) begin
        rxBufQ  <= rxByte;
        rxFullQ <= 1'b1;
      end else if (rdRx || (wrStat && !wdata[2])) begin
        rxFullQ <= 1'b0;
      end
    end
  end

  always_comb begin
    cmd.start    = wrTx && !busy;
    cmd.txByte   = wdata[BYTE_W-1:0];
    cmd.cpha     = cfgQ[7];
    cmd.cpol     = cfgQ[6];
    cmd.coarseHi = cfgQ[5];
    cmd.fineN    = cfgQ[FINE_W-1:0];
  end

  always_comb begin
    unique case (addr)
      OFS_CFG:  rdata = {{PAD{1'b0}}, cfgQ};
      OFS_STAT: rdata = {{(BUS_W-3){1'b0}}, rxFullQ, 1'b0, busy};
      OFS_SYS:  rdata = {{PAD{1'b0}}, sysQ};
      OFS_RX:   rdata = {{PAD{1'b0}}, rxBufQ};
      OFS_CFG2: rdata = {{PAD{1'b0}}, cfg2Q};
      default:  rdata = '0;
    endcase
  end

  assign csN = sysQ[6];

  a_r7_done_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    done |=> rxFullQ);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && !done) |=> !rxFullQ);
  a_r10_busy_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && busy) |-> !cmd.start);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        csN
);
  spimCmd_t          cmd;
  logic              busy, done;
  logic [BYTE_W-1:0] rxByte;

  spim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
    .rxByte(rxByte), .cmd(cmd), .csN(csN)
  );

  spim_datapath #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .miso(miso), .sck(sck),
    .mosi(mosi), .busy(busy), .done(done), .rxByte(rxByte)
  );

  a_r2_cs_follows: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_SYS) |=> (csN == $past(wdata[6])));
endmodule

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, miso, csN;

  int checks = 0, failures = 0;
  bit finished = 0;

  // device model
  logic       slvArm = 1'b0, slvCpha = 1'b0;
  logic [7:0] slvOut = '0, slvIn = '0;
  int         sEdge = 0;
  time        lastT = 0;
  int         gapBad = 0;
  time        expGap = 0;

  assign miso = slvOut[7];

  always #10 clk = ~clk;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .csN(csN)
  );

  always @(sck) begin
    if (slvArm) begin
      sEdge = sEdge + 1;
      if (sEdge > 1 && ($time - lastT) != expGap) gapBad = gapBad + 1;
      lastT = $time;
      if (sEdge % 2 == 1) begin
        if (!slvCpha) slvIn = {slvIn[6:0], mosi};
        else if (sEdge != 1) slvOut = {slvOut[6:0], 1'b0};
      end else begin
        if (!slvCpha) slvOut = {slvOut[6:0], 1'b0};
        else slvIn = {slvIn[6:0], mosi};
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      busRead(5'h04, s);
      if (!s[0]) break;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 csN", {31'b0, csN}, 1);
    check("R1 sck", {31'b0, sck}, 0);
    busRead(5'h00, d); check("R1 cfg", d, 0);
    busRead(5'h04, d); check("R1 status", d, 0);
    busRead(5'h08, d); check("R1 sys", d, 32'h40);
    busRead(5'h10, d); check("R1 rx", d, 0);
    busRead(5'h14, d); check("R1 cfg2", d, 0);
  endtask

  task automatic testSelect();
    logic [31:0] d;
    busWrite(5'h08, 32'h21);
    busRead(5'h08, d); check("R2 sys readback", d, 32'h21);
    check("R2 csN low", {31'b0, csN}, 0);
    busWrite(5'h08, 32'h61);
    check("R2 csN high", {31'b0, csN}, 1);
    busWrite(5'h08, 32'h21);
    check("R2 csN low again", {31'b0, csN}, 0);
  endtask

  task automatic testIdle();
    busWrite(5'h00, 32'h40);
    @(negedge clk);
    check("R3 idle high", {31'b0, sck}, 1);
    busWrite(5'h00, 32'h00);
    @(negedge clk);
    check("R3 idle low", {31'b0, sck}, 0);
  endtask

  task automatic xfer(bit cpol, bit cpha, bit hi, int n, logic [7:0] tx, logic [7:0] pat);
    logic [31:0] d;
    busWrite(5'h00, {24'b0, cpha, cpol, hi, 5'(n)});
    repeat (2) @(negedge clk);
    slvCpha = cpha; slvOut = pat; slvIn = '0; sEdge = 0; gapBad = 0;
    expGap = (hi ? 128 : 16) * (n + 1) * 20;
    slvArm = 1'b1;
    busWrite(5'h0C, {24'b0, tx});
    busRead(5'h04, d); check("R5 busy set", {31'b0, d[0]}, 1);
    waitIdle();
    slvArm = 1'b0;
    check("R4 half period", gapBad, 0);
    check("R6 edge count", sEdge, 16);
    check("R6 rest level", {31'b0, sck}, {31'b0, cpol});
    check("R6 bits seen by device", {24'b0, slvIn}, {24'b0, tx});
    busRead(5'h04, d); check("R7 rx full", d, 32'h4);
    busRead(5'h10, d); check("R7 rx byte", d, {24'b0, pat});
    busRead(5'h04, d); check("R8 cleared by read", d, 0);
  endtask

  task automatic testStatusClear();
    logic [31:0] d;
    xfer(0, 0, 0, 0, 8'h0F, 8'hF0);
    busWrite(5'h0C, 32'h11);
    waitIdle();
    busRead(5'h04, d); check("R9 full before clear", d, 32'h4);
    busWrite(5'h04, 32'h0);
    busRead(5'h04, d); check("R9 cleared by write", d, 0);
  endtask

  task automatic testBusyWrite();
    logic [31:0] d;
    busWrite(5'h00, 32'h00);
    repeat (2) @(negedge clk);
    slvCpha = 0; slvOut = 8'h96; slvIn = '0; sEdge = 0; gapBad = 0; expGap = 320;
    slvArm = 1'b1;
    busWrite(5'h0C, 32'hA5);
    repeat (5) @(negedge clk);
    busWrite(5'h0C, 32'h3C);
    waitIdle();
    repeat (400) @(negedge clk);
    slvArm = 1'b0;
    check("R10 byte unchanged", {24'b0, slvIn}, 32'hA5);
    check("R10 no second transfer", sEdge, 16);
    busRead(5'h10, d); check("R10 rx byte", d, 32'h96);
  endtask

  task automatic testCfg2();
    logic [31:0] d;
    busWrite(5'h14, 32'hFFFF_FF5A);
    busRead(5'h14, d); check("R11 cfg2 readback", d, 32'h5A);
    busRead(5'h0C, d); check("R11 tx reads zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSelect();
    testIdle();
    xfer(0, 0, 0, 0, 8'hA5, 8'h5A);
    xfer(1, 0, 0, 2, 8'h81, 8'h7E);
    xfer(0, 1, 1, 0, 8'h3C, 8'hC3);
    xfer(1, 1, 0, 5, 8'hE1, 8'h1D);
    testStatusClear();
    testBusyWrite();
    testCfg2();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule